// File: doc/BRIEF.md
# Calendar Timekeeping Core with Deferred Register Commit

This block keeps wall-clock time and calendar date, advanced by a one-second pulse from the slow clock domain. The time word holds seconds, minutes and hours. The date word holds day of month, month, a year offset counted from a configurable base year, and a leap-year flag. Software reaches both words, and a control word, over a plain memory-mapped read/write port with combinational read data.

A write to the time or date word is not applied at once. The written value is held in a staging register. After a programmable number of cycles it is committed to the visible word. Until then, a per-word busy flag in the control word stays high and reads still return the old value. While a word has a commit in flight, its one-second advance is suppressed, so the value software wrote is never overtaken by a tick.

Rollover covers every field, from seconds through to years. It uses the usual month lengths, with a 29-day February when the leap flag is set. The leap flag is recomputed from the Gregorian rule each time the year offset steps.

Top module: `rtcCalendar`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0x00000000 and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag equal to the rule applied to BASE_YEAR; 0 for the default 2010).
- R2: The time word is at offset 0x08 with seconds in [5:0], minutes in [13:8] and hours in [20:16]; every other bit reads 0 (writing 0xFFFFFFFF reads back 0x001F3F3F once committed).
- R3: The date word is at offset 0x04 with day in [4:0], month (1..12) in [11:8], year offset in [16+YEAR_W-1:16] and the leap flag at bit 16+YEAR_W (bit 22 for YEAR_W=6, bit 24 for YEAR_W=8); other bits read 0 (0xFFFFFFFF reads back 0x007F0F1F at YEAR_W=6).
- R4: A time write sets control bit 8 from the next cycle for exactly COMMIT_CYCLES cycles (COMMIT_CYCLES >= 2); during those cycles the time word reads its old value; the new value appears in the same cycle that bit 8 clears.
- R5: A date write sets control bit 7 with the same timing and read-old-value behaviour, independent of bit 8.
- R6: A value of zero is committed like any other value; a second write to a word that is still busy replaces the staged value and restarts its full commit window.
- R7: Each tick advances seconds; 59 seconds wraps to 0 and carries into minutes, 59 minutes wraps to 0 and carries into hours, and 23 hours wraps to 0 and carries into the date.
- R8: On a day carry, the day wraps to 1 and the month advances after day 30 for months 4, 6, 9 and 11, after day 31 for the other months, and after day 28 (leap flag 0) or 29 (leap flag 1) for month 2; month 12 wraps to 1 with a year carry.
- R9: A year carry increments the year offset modulo 2^YEAR_W and sets the leap flag from BASE_YEAR plus the new offset, using the divisible-by-4, not-by-100-unless-by-400 rule.
- R10: While the time word is busy, ticks change neither word; while only the date word is busy, ticks still advance the time word but a day carry is discarded.
- R11: A day rollover changes the time word and the date word on the same clock edge, so reading both in any one cycle never mixes an old and a new value.
- R12: Writes to the control word at offset 0x00, and writes to any unmapped offset, change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| busAddr | input | 4 | Byte offset of the accessed word |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |

## Verification
The rollover logic is driven from a table of start points, each placed just before one boundary. There is a plain seconds step, the minute and hour carries, and the ends of a 31-day, a 30-day and a February month with and without the leap flag. There is also a December rollover into a leap and a non-leap year, and the year-offset wrap. Each table entry tells apart one length rule or carry path from its neighbours. Directed sequences then count cycles on the busy flags, overlap a write with a still-pending one, and tick during each word's commit window. These sequences show the difference between a suppressed advance and a lost carry. Writes of all ones and of zero check the field masks and show that zero is an ordinary value.

// File: rtl/rtcPkg.sv
package rtcPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTime;   // commit staged time word
    logic loadDate;   // commit staged date word
    logic advTime;    // tick may advance the time word
    logic advDate;    // tick carry may advance the date word
  } rtcStrobeT;

  localparam int CH_TIME = 0;
  localparam int CH_DATE = 1;
  localparam int NUM_CH  = 2;

endpackage

// File: rtl/rtcCommitTimer.sv
module rtcCommitTimer #(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrStart,
  output logic busy,
  output logic commit
);
  localparam int CNT_W = (COMMIT_CYCLES > 2) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  // a fresh write in the commit cycle cancels the commit and restarts
  assign commit = busy && (cnt == '0) && !wrStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (wrStart) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (commit) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> busy && !commit); // R4
  AST_COMMIT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !busy); // R4
  AST_COMMIT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> $past(busy)); // R6

endmodule

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrTime,
  input  logic      wrDate,
  input  logic      secTick,
  output rtcStrobeT strb,
  output logic      timeBusy,
  output logic      dateBusy
);
  logic [NUM_CH-1:0] wrVec;
  logic [NUM_CH-1:0] busyVec;
  logic [NUM_CH-1:0] commitVec;

  assign wrVec[CH_TIME] = wrTime;
  assign wrVec[CH_DATE] = wrDate;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    rtcCommitTimer #(.COMMIT_CYCLES(COMMIT_CYCLES)) i_timer (
      .clk    (clk),
      .rstN   (rstN),
      .wrStart(wrVec[g]),
      .busy   (busyVec[g]),
      .commit (commitVec[g])
    );
  end

  assign timeBusy = busyVec[CH_TIME];
  assign dateBusy = busyVec[CH_DATE];

  always_comb begin
    strb.loadTime = commitVec[CH_TIME];
    strb.loadDate = commitVec[CH_DATE];
    strb.advTime  = secTick && !busyVec[CH_TIME];
    strb.advDate  = secTick && !busyVec[CH_DATE];
  end

  AST_NO_ADVANCE_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadTime && strb.advTime)); // R10

endmodule

// File: rtl/rtcData.sv
module rtcData
  import rtcPkg::*;
#(
  parameter int YEAR_W    = 6,
  parameter int BASE_YEAR = 2010
) (
  input  logic        clk,
  input  logic        rstN,
  input  rtcStrobeT   strb,
  input  logic        wrTime,
  input  logic        wrDate,
  input  logic [31:0] wrData,
  output logic [31:0] timeWord,
  output logic [31:0] dateWord
);
  localparam int LEAP_POS = 16 + YEAR_W;

  function automatic logic leapRule(input int y);
    return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
  endfunction

  function automatic logic [4:0] monthLen(input logic [3:0] m, input logic lp);
    case (m)
      4'd2:                     return lp ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  localparam logic RESET_LEAP = leapRule(BASE_YEAR);

  // visible state
  logic [5:0]        secQ, minQ;
  logic [4:0]        hourQ;
  logic [4:0]        dayQ;
  logic [3:0]        monthQ;
  logic [YEAR_W-1:0] yearQ;
  logic              leapQ;

  // staged values waiting for commit
  logic [5:0]        stSec, stMin;
  logic [4:0]        stHour, stDay;
  logic [3:0]        stMonth;
  logic [YEAR_W-1:0] stYear;
  logic              stLeap;

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  // next-state for one tick
  logic [5:0]        nSec, nMin;
  logic [4:0]        nHour, nDay;
  logic [3:0]        nMonth;
  logic [YEAR_W-1:0] nYear;
  logic              nLeap;
  logic              minCarry, hourCarry, dayCarry, monthCarry, yearCarry;

  always_comb begin
    minCarry   = (secQ >= 6'd59);
    hourCarry  = minCarry && (minQ >= 6'd59);
    dayCarry   = hourCarry && (hourQ >= 5'd23);
    monthCarry = dayCarry && (dayQ >= monthLen(monthQ, leapQ));
    yearCarry  = monthCarry && (monthQ >= 4'd12);

    nSec  = minCarry  ? 6'd0 : secQ + 6'd1;
    nMin  = hourCarry ? 6'd0 : (minCarry ? minQ + 6'd1 : minQ);
    nHour = dayCarry  ? 5'd0 : (hourCarry ? hourQ + 5'd1 : hourQ);

    nDay   = monthCarry ? 5'd1 : dayQ + 5'd1;
    nMonth = yearCarry ? 4'd1 : (monthCarry ? monthQ + 4'd1 : monthQ);
    nYear  = yearCarry ? yearQ + 1'b1 : yearQ;
    nLeap  = yearCarry ? leapRule(BASE_YEAR + int'(nYear)) : leapQ;
  end

  // staging registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stSec  <= '0;
      stMin  <= '0;
      stHour <= '0;
    end else if (wrTime) begin
      stSec  <= wrData[5:0];
      stMin  <= wrData[13:8];
      stHour <= wrData[20:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stDay   <= 5'd1;
      stMonth <= 4'd1;
      stYear  <= '0;
      stLeap  <= 1'b0;
    end else if (wrDate) begin
      stDay   <= wrData[4:0];
      stMonth <= wrData[11:8];
      stYear  <= wrData[16 +: YEAR_W];
      stLeap  <= wrData[LEAP_POS];
    end
  end

  // visible time and date, updated on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
    end else if (strb.loadTime) begin
      secQ  <= stSec;
      minQ  <= stMin;
      hourQ <= stHour;
    end else if (strb.advTime) begin
      secQ  <= nSec;
      minQ  <= nMin;
      hourQ <= nHour;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dayQ   <= 5'd1;
      monthQ <= 4'd1;
      yearQ  <= '0;
      leapQ  <= RESET_LEAP;
    end else if (strb.loadDate) begin
      dayQ   <= stDay;
      monthQ <= stMonth;
      yearQ  <= stYear;
      leapQ  <= stLeap;
    end else if (strb.advTime && strb.advDate && dayCarry) begin
      dayQ   <= nDay;
      monthQ <= nMonth;
      yearQ  <= nYear;
      leapQ  <= nLeap;
    end
  end

  always_comb begin
    timeWord        = '0;
    timeWord[5:0]   = secQ;
    timeWord[13:8]  = minQ;
    timeWord[20:16] = hourQ;
    dateWord                  = '0;
    dateWord[4:0]             = dayQ;
    dateWord[11:8]            = monthQ;
    dateWord[16 +: YEAR_W]    = yearQ;
    dateWord[LEAP_POS]        = leapQ;
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.advTime && !strb.loadTime && secQ == 6'd59 |=> secQ == 6'd0); // R7
  AST_DAY_ROLL_SAME_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.advTime && strb.advDate && dayCarry && !strb.loadDate
    |=> hourQ == 5'd0 && dayQ != $past(dayQ)); // R11
  AST_NEW_YEAR_JAN1: assert property (@(posedge clk) disable iff (!rstN)
    strb.advTime && strb.advDate && yearCarry && !strb.loadDate
    |=> dayQ == 5'd1 && monthQ == 4'd1); // R9

endmodule

// File: rtl/rtcCalendar.sv
module rtcCalendar
  import rtcPkg::*;
#(
  parameter int COMMIT_CYCLES = 4,
  parameter int YEAR_W        = 6,
  parameter int BASE_YEAR     = 2010,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData
);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] DATE_OFF = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] TIME_OFF = ADDR_W'(8'h08);
  localparam int TIME_BUSY_BIT = 8;
  localparam int DATE_BUSY_BIT = 7;

  rtcStrobeT   strb;
  logic        timeBusy, dateBusy;
  logic        wrTime, wrDate;
  logic [31:0] timeWord, dateWord, ctrlWord;

  assign wrTime = busWrEn && (busAddr == TIME_OFF);
  assign wrDate = busWrEn && (busAddr == DATE_OFF);

  rtcCtrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrTime  (wrTime),
    .wrDate  (wrDate),
    .secTick (secTick),
    .strb    (strb),
    .timeBusy(timeBusy),
    .dateBusy(dateBusy)
  );

  rtcData #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrTime  (wrTime),
    .wrDate  (wrDate),
    .wrData  (busWrData),
    .timeWord(timeWord),
    .dateWord(dateWord)
  );

  always_comb begin
    ctrlWord                = '0;
    ctrlWord[TIME_BUSY_BIT] = timeBusy;
    ctrlWord[DATE_BUSY_BIT] = dateBusy;
  end

  always_comb begin
    case (busAddr)
      CTRL_OFF: busRdData = ctrlWord;
      DATE_OFF: busRdData = dateWord;
      TIME_OFF: busRdData = timeWord;
      default:  busRdData = '0;
    endcase
  end

  AST_TIME_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    timeBusy && !strb.loadTime |=> $stable(timeWord)); // R10
  AST_DATE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dateBusy && !strb.loadDate |=> $stable(dateWord)); // R5
  AST_IDLE_TIME_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !secTick && !timeBusy && !wrTime |=> $stable(timeWord)); // R12

endmodule

// File: tb/test_rtcCalendar.sv
`timescale 1ns/10ps
module test_rtcCalendar;
  localparam int C = 4;
  localparam logic [3:0] A_CTRL = 4'h0, A_DATE = 4'h4, A_TIME = 4'h8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  rtcCalendar #(.COMMIT_CYCLES(C), .YEAR_W(6), .BASE_YEAR(2010), .ADDR_W(4)) i_rtcCalendar (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  typedef struct packed {
    logic [31:0] tIn;
    logic [31:0] dIn;
    logic [31:0] nTick;
    logic [31:0] tExp;
    logic [31:0] dExp;
  } vecT;

  localparam vecT VECS [14] = '{
    '{32'h00000000, 32'h00000101, 32'd1, 32'h00000001, 32'h00000101},
    '{32'h0000003B, 32'h00000101, 32'd1, 32'h00000100, 32'h00000101},
    '{32'h00003B3B, 32'h00000101, 32'd1, 32'h00010000, 32'h00000101},
    '{32'h000C2238, 32'h00000101, 32'd3, 32'h000C223B, 32'h00000101},
    '{32'h00173B3B, 32'h0000011F, 32'd1, 32'h00000000, 32'h00000201},
    '{32'h00173B3B, 32'h0000010F, 32'd1, 32'h00000000, 32'h00000110},
    '{32'h00173B3B, 32'h0001021C, 32'd1, 32'h00000000, 32'h00010301},
    '{32'h00173B3B, 32'h0042021C, 32'd1, 32'h00000000, 32'h0042021D},
    '{32'h00173B3B, 32'h0042021D, 32'd1, 32'h00000000, 32'h00420301},
    '{32'h00173B3B, 32'h0000041E, 32'd1, 32'h00000000, 32'h00000501},
    '{32'h00173B3B, 32'h0000071F, 32'd1, 32'h00000000, 32'h00000801},
    '{32'h00173B3B, 32'h00010C1F, 32'd1, 32'h00000000, 32'h00420101},
    '{32'h00173B3B, 32'h00050C1F, 32'd1, 32'h00000000, 32'h00460101},
    '{32'h00173B3B, 32'h003F0C1F, 32'd1, 32'h00000000, 32'h00000101}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busAddr = a;
    #0.1;
    v = busRdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    secTick = 1'b1;
    repeat (n) @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic settle();
    repeat (C + 2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_TIME, v); check("R1 time", v, 32'h0);
    rd(A_DATE, v); check("R1 date", v, 32'h00000101);

    // R4 time commit window
    wr(A_TIME, 32'h00050403);
    for (int k = 0; k < C; k++) begin
      rd(A_CTRL, c); check("R4 busy during window", c, 32'h00000100);
      rd(A_TIME, v); check("R4 old value during window", v, 32'h0);
      @(negedge clk);
    end
    rd(A_CTRL, c); check("R4 busy cleared", c, 32'h0);
    rd(A_TIME, v); check("R4 committed value", v, 32'h00050403);

    // R5 date commit window
    wr(A_DATE, 32'h00030A0F);
    for (int k = 0; k < C; k++) begin
      rd(A_CTRL, c); check("R5 busy during window", c, 32'h00000080);
      rd(A_DATE, v); check("R5 old value during window", v, 32'h00000101);
      @(negedge clk);
    end
    rd(A_CTRL, c); check("R5 busy cleared", c, 32'h0);
    rd(A_DATE, v); check("R5 committed value", v, 32'h00030A0F);

    // R6 restart on rewrite, last value wins
    wr(A_TIME, 32'h00010101);
    @(negedge clk);
    wr(A_TIME, 32'h00020202);
    @(negedge clk);
    rd(A_CTRL, c); check("R6 still busy after first window", c, 32'h00000100);
    rd(A_TIME, v); check("R6 no early commit", v, 32'h00050403);
    repeat (3) @(negedge clk);
    rd(A_CTRL, c); check("R6 busy cleared after restart", c, 32'h0);
    rd(A_TIME, v); check("R6 last write wins", v, 32'h00020202);
    wr(A_TIME, 32'h0); settle();
    rd(A_TIME, v); check("R6 zero committed", v, 32'h0);

    // R2 R3 field masks
    wr(A_TIME, 32'hFFFFFFFF); settle();
    rd(A_TIME, v); check("R2 time field mask", v, 32'h001F3F3F);
    wr(A_DATE, 32'hFFFFFFFF); settle();
    rd(A_DATE, v); check("R3 date field mask", v, 32'h007F0F1F);

    // R7 R8 R9 R11 rollover table
    for (int i = 0; i < 14; i++) begin
      wr(A_TIME, VECS[i].tIn);
      wr(A_DATE, VECS[i].dIn);
      settle();
      ticks(int'(VECS[i].nTick));
      rd(A_TIME, v); check($sformatf("R7 R11 time vector %0d", i), v, VECS[i].tExp);
      rd(A_DATE, v); check($sformatf("R8 R9 R11 date vector %0d", i), v, VECS[i].dExp);
    end

    // R10 time busy blocks ticks
    wr(A_TIME, 32'h000A0000);
    secTick = 1'b1;
    repeat (3) @(negedge clk);
    secTick = 1'b0;
    settle();
    rd(A_TIME, v); check("R10 ticks ignored while time busy", v, 32'h000A0000);
    ticks(1);
    rd(A_TIME, v); check("R10 tick resumes after commit", v, 32'h000A0001);

    // R10 date busy drops the day carry
    wr(A_TIME, 32'h00173B3B); settle();
    wr(A_DATE, 32'h00000305);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    settle();
    rd(A_TIME, v); check("R10 time advances while date busy", v, 32'h0);
    rd(A_DATE, v); check("R10 day carry dropped", v, 32'h00000305);

    // R12 ignored writes
    wr(A_CTRL, 32'hFFFFFFFF);
    rd(A_CTRL, c); check("R12 ctrl write ignored", c, 32'h0);
    wr(4'hC, 32'h12345678); settle();
    rd(A_TIME, v); check("R12 unmapped write time", v, 32'h0);
    rd(A_DATE, v); check("R12 unmapped write date", v, 32'h00000305);
    rd(4'hC, v);   check("R12 unmapped reads zero", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule